// File: doc/BRIEF.md
# Fault alarm response controller

This block sits between a set of fault detectors and a processor pipeline. The detectors can watch for events such as clock glitches or supply droop. Each enabled detector can raise an alarm. The controller merges the enabled alarms into one fault indication and answers it with a fixed hardware containment sequence. The sequence ends by handing control to a software trap handler.

The controller acknowledges the alarm. In the same cycle it freezes the checkpoint registers, squashes every instruction in flight, and blocks writes to the register file and to data memory. It then requests a trap to a fixed vector and keeps the write blocks asserted until the pipeline reports that trap entry has happened. While the handler runs, the checkpoint stays frozen. A completion pulse from the handler returns the block to its idle state.

An alarm that arrives while a sequence is already running does not restart the sequence. It sets a sticky flag that only reset clears.

Top module: `fault_resp_ctrl`

## Requirements
- R1: While idle with no enabled alarm, ack, lock, annul, rf_wr_dis, mem_wr_dis and trap_req are all 0 and trap_vec is 0, so the block adds no stalls.
- R2: The fault indication is the OR of all bits of det_alarm & det_en. Any single enabled bit, at any position, starts the sequence.
- R3: An enabled alarm sampled at a clock edge while idle makes ack 1 for exactly the following cycle.
- R4: In the ack cycle, lock, annul, rf_wr_dis and mem_wr_dis are all 1 and trap_req is 0. annul is 1 in that cycle only.
- R5: In the cycle after ack, trap_req is 1 and trap_vec equals the TRAP_VECTOR parameter, with lock, rf_wr_dis and mem_wr_dis still 1. This state holds until trap_taken is sampled high.
- R6: After trap_taken is sampled high, trap_req, rf_wr_dis and mem_wr_dis drop to 0 and lock stays 1 until handler_done is sampled high.
- R7: A handler_done sampled high while the handler runs makes lock 0 in the next cycle and returns the block to idle, ready for a new alarm.
- R8: An alarm on a detector whose det_en bit is 0 is ignored: no ack and no other output rises.
- R9: An enabled alarm while not idle produces no new ack and does not change the running sequence. It sets late_alarm to 1, and late_alarm stays 1 until reset.
- R10: After reset (rst_n low), all outputs, including late_alarm, are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_alarm | input | N_DET | Alarm inputs, one per detector |
| det_en | input | N_DET | Per-detector enable mask |
| trap_taken | input | 1 | Pipeline has entered the trap vector |
| handler_done | input | 1 | Trap handler has finished |
| ack | output | 1 | Alarm acknowledge to the detection unit |
| lock | output | 1 | Freeze the checkpoint registers |
| annul | output | 1 | Squash all in-flight instructions |
| rf_wr_dis | output | 1 | Block register-file writes |
| mem_wr_dis | output | 1 | Block data-memory writes |
| trap_req | output | 1 | Request redirect of fetch to trap_vec |
| trap_vec | output | VEC_W | Trap address while trap_req is 1, else 0 |
| late_alarm | output | 1 | Sticky flag for alarms seen outside idle |

## Verification
The bench builds the block with N_DET = 4, VEC_W = 32 and TRAP_VECTOR = 0x0F00. With four detectors, the vector table can set the lowest bit, the highest bit and middle bits. It can also combine alarm and mask patterns where the set bits overlap and where they miss each other. The 32-bit vector is a distinctive non-zero value, so a trap address that is wrong, or that leaks outside the trap state, shows up at the port. Directed cases hold trap_taken low for several cycles and inject alarms while the trap request and the handler are active. They also check that the late flag survives the return to idle and is cleared by reset.

// File: rtl/fault_resp_ctrl.sv
module fault_resp_ctrl #(
  parameter int N_DET = 4,
  parameter int VEC_W = 32,
  parameter logic [VEC_W-1:0] TRAP_VECTOR = 'h0F00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DET-1:0] det_alarm,
  input  logic [N_DET-1:0] det_en,
  input  logic             trap_taken,
  input  logic             handler_done,
  output logic             ack,
  output logic             lock,
  output logic             annul,
  output logic             rf_wr_dis,
  output logic             mem_wr_dis,
  output logic             trap_req,
  output logic [VEC_W-1:0] trap_vec,
  output logic             late_alarm
);
  typedef enum logic [1:0] {S_NOM, S_CONT, S_TRAP, S_HND} st_t;

  st_t st;
  logic fault;

  assign fault = |(det_alarm & det_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_NOM;
    end else begin
      case (st)
        S_NOM:   if (fault) st <= S_CONT;
        S_CONT:  st <= S_TRAP;
        S_TRAP:  if (trap_taken) st <= S_HND;
        S_HND:   if (handler_done) st <= S_NOM;
        default: st <= S_NOM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) late_alarm <= 1'b0;
    else if (fault && st != S_NOM) late_alarm <= 1'b1;
  end

  assign ack        = (st == S_CONT);
  assign annul      = (st == S_CONT);
  assign lock       = (st != S_NOM);
  assign rf_wr_dis  = (st == S_CONT) || (st == S_TRAP);
  assign mem_wr_dis = (st == S_CONT) || (st == S_TRAP);
  assign trap_req   = (st == S_TRAP);
  assign trap_vec   = trap_req ? TRAP_VECTOR : '0;
endmodule

// File: rtl/fault_resp_chk.sv
module fault_resp_chk #(
  parameter int N_DET = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_DET-1:0] det_alarm,
  input logic [N_DET-1:0] det_en,
  input logic             handler_done,
  input logic             ack,
  input logic             lock,
  input logic             annul,
  input logic             rf_wr_dis,
  input logic             mem_wr_dis,
  input logic             trap_req,
  input logic             late_alarm
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |-> !(ack || annul || rf_wr_dis || mem_wr_dis || trap_req));

  a_r4_contain_all: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (lock && annul && rf_wr_dis && mem_wr_dis && !trap_req));

  a_r3_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r5_trap_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (trap_req && rf_wr_dis && mem_wr_dis && lock));

  a_r8_masked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock && ((det_alarm & det_en) == '0)) |=> !ack);

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !ack && !trap_req && handler_done) |=> !lock);

  a_r9_late_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    late_alarm |=> late_alarm);
endmodule

bind fault_resp_ctrl fault_resp_chk #(.N_DET(N_DET)) u_chk (
  .clk(clk), .rst_n(rst_n), .det_alarm(det_alarm), .det_en(det_en),
  .handler_done(handler_done), .ack(ack), .lock(lock), .annul(annul),
  .rf_wr_dis(rf_wr_dis), .mem_wr_dis(mem_wr_dis), .trap_req(trap_req),
  .late_alarm(late_alarm)
);

// File: tb/fault_resp_ctrl_test.sv
module fault_resp_ctrl_test;
  localparam int N = 4;
  localparam logic [31:0] VEC = 32'h0000_0F00;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] det_alarm = '0, det_en = '0;
  logic trap_taken = 1'b0, handler_done = 1'b0;
  logic ack, lock, annul, rf_wr_dis, mem_wr_dis, trap_req, late_alarm;
  logic [31:0] trap_vec;

  int runs = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fault_resp_ctrl #(.N_DET(N), .VEC_W(32), .TRAP_VECTOR(VEC)) uut (
    .clk(clk), .rst_n(rst_n), .det_alarm(det_alarm), .det_en(det_en),
    .trap_taken(trap_taken), .handler_done(handler_done), .ack(ack),
    .lock(lock), .annul(annul), .rf_wr_dis(rf_wr_dis), .mem_wr_dis(mem_wr_dis),
    .trap_req(trap_req), .trap_vec(trap_vec), .late_alarm(late_alarm)
  );

  // {alarm, enable, expect_start}
  localparam logic [8:0] TBL [8] = '{
    {4'b0000, 4'b1111, 1'b0},
    {4'b0001, 4'b1111, 1'b1},
    {4'b1000, 4'b1111, 1'b1},
    {4'b0100, 4'b1011, 1'b0},
    {4'b0100, 4'b0100, 1'b1},
    {4'b1111, 4'b0000, 1'b0},
    {4'b0010, 4'b0011, 1'b1},
    {4'b1010, 4'b0101, 1'b0}
  };

  // packed view: {ack, lock, annul, rf, mem, trap_req}
  function automatic logic [5:0] outs();
    return {ack, lock, annul, rf_wr_dis, mem_wr_dis, trap_req};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    det_alarm = '0; trap_taken = 1'b0; handler_done = 1'b0;
    step();
    rst_n = 1'b1;
    step();
  endtask

  initial begin
    do_reset();
    chk("R10 reset outs", {26'd0, outs()}, 32'd0);
    chk("R10 reset late", {31'd0, late_alarm}, 32'd0);
    chk("R1 idle vec", trap_vec, 32'd0);

    foreach (TBL[i]) begin
      det_alarm = TBL[i][8:5];
      det_en    = TBL[i][4:1];
      step();
      det_alarm = '0;
      if (TBL[i][0]) begin
        chk("R2 R3 R4 contain", {26'd0, outs()}, 32'b111110);
        step();
        chk("R5 trap req", {26'd0, outs()}, 32'b010111);
        chk("R5 trap vec", trap_vec, VEC);
        trap_taken = 1'b1;
        step();
        trap_taken = 1'b0;
        chk("R6 handler", {26'd0, outs()}, 32'b010000);
        handler_done = 1'b1;
        step();
        handler_done = 1'b0;
        chk("R7 return", {26'd0, outs()}, 32'd0);
      end else begin
        chk("R8 R1 masked quiet", {26'd0, outs()}, 32'd0);
      end
    end
    chk("R9 no late yet", {31'd0, late_alarm}, 32'd0);

    det_en = 4'b1111;
    det_alarm = 4'b0001;
    step();
    chk("R3 ack", {31'd0, ack}, 32'd1);
    step();
    chk("R5 trap", {31'd0, trap_req}, 32'd1);
    det_alarm = 4'b0100;
    step();
    chk("R9 no restart in trap", {26'd0, outs()}, 32'b010111);
    chk("R9 late set", {31'd0, late_alarm}, 32'd1);
    det_alarm = '0;
    step();
    step();
    chk("R5 held without taken", {26'd0, outs()}, 32'b010111);
    chk("R5 vec held", trap_vec, VEC);
    trap_taken = 1'b1;
    step();
    trap_taken = 1'b0;
    chk("R6 writes released", {26'd0, outs()}, 32'b010000);
    det_alarm = 4'b1000;
    step();
    det_alarm = '0;
    chk("R9 no restart in handler", {26'd0, outs()}, 32'b010000);
    step();
    chk("R6 lock held", {31'd0, lock}, 32'd1);
    handler_done = 1'b1;
    step();
    handler_done = 1'b0;
    chk("R7 idle again", {26'd0, outs()}, 32'd0);
    chk("R9 late sticky", {31'd0, late_alarm}, 32'd1);

    det_alarm = 4'b0010;
    step();
    det_alarm = '0;
    chk("R7 rearmed", {26'd0, outs()}, 32'b111110);
    step();
    chk("R4 annul one cycle", {31'd0, annul}, 32'd0);

    do_reset();
    chk("R10 late cleared", {31'd0, late_alarm}, 32'd0);
    chk("R10 outs cleared", {26'd0, outs()}, 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      runs++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule